// File: doc/BRIEF.md
# Bit-Test Conditional Skip Unit

This unit handles two bit-test-and-skip operations for a small 8-bit accumulator-style core. A test instruction names a data register with a 7-bit address and one of its eight bits with a 3-bit index. The unit puts the address on a read port and takes the returned byte in the same cycle. It then picks out the chosen bit and decides whether the instruction that follows must be turned into a NOP. One variant skips when the bit is 1. The other skips when the bit is 0.

The unit does not redirect fetch. When a skip is taken, it records a pending skip in a register. The next valid pipeline slot is then squashed to a NOP, so a taken test costs two instruction cycles and an untaken test costs one. No status flag is touched.

The control is a two-state machine:
- **ST_EVAL**: no skip is pending. A valid test instruction is evaluated here.
- **ST_PEND**: a skip is waiting for the next valid slot.

Its transitions are:
- **T_TAKE** (ST_EVAL to ST_PEND): an evaluated test meets its condition.
- **T_STAY** (ST_EVAL to ST_EVAL): nothing is taken.
- **T_WAIT** (ST_PEND to ST_PEND): the slot is invalid.
- **T_SQUASH** (ST_PEND to ST_EVAL): a valid slot arrives and is squashed.

Top module: `bts_skip_unit`

## Requirements
- R1: `rd_addr_o` equals `reg_addr_i` in every cycle, with no register in the path.
- R2: Opcode 2'b01 (skip-if-set), when evaluated, takes the skip exactly when the selected bit of `rd_data_i` is 1.
- R3: Opcode 2'b10 (skip-if-clear), when evaluated, takes the skip exactly when the selected bit of `rd_data_i` is 0.
- R4: `bit_sel_i` value n (0 to 7) selects bit n of `rd_data_i`, with bit 0 as the least significant.
- R5: A taken skip raises `skip_pend_o` from the next cycle. The next valid slot sees `squash_o` high, and `skip_pend_o` is low in the cycle after that slot.
- R6: Cycles with `slot_valid_i` low neither consume a pending skip nor assert `squash_o`.
- R7: A squashed slot is never evaluated, even when it holds a test opcode. `two_cyc_o` stays low and no new skip becomes pending.
- R8: `two_cyc_o` is high in a cycle exactly when a valid, unsquashed test instruction takes its skip. An untaken test shows 0.
- R9: While `rst_n` is low and right after it, no skip is pending and `squash_o` is low. This holds even when reset lands with a skip pending.
- R10: Opcodes 2'b00 and 2'b11 are not test instructions. They never take a skip or raise `two_cyc_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slot_valid_i | input | 1 | The current pipeline slot holds an instruction |
| op_i | input | 2 | Instruction class: 01 skip-if-set, 10 skip-if-clear, other values not a test |
| reg_addr_i | input | 7 | Register address operand |
| bit_sel_i | input | 3 | Bit index operand |
| rd_data_i | input | 8 | Byte read from the addressed register |
| rd_addr_o | output | 7 | Register read address |
| squash_o | output | 1 | The current slot is replaced by a NOP |
| skip_pend_o | output | 1 | Registered skip request for the next valid slot |
| two_cyc_o | output | 1 | The current test instruction takes two cycles |

## Verification
The assertions assume that `rd_data_i` is a combinational response to `rd_addr_o` within the same cycle. They also assume that `op_i` is meaningful only while `slot_valid_i` is high. The bench drives read data from a register array indexed by the address output, so the returned byte always belongs to the current instruction. It also drives arbitrary operand values during invalid slots, which shows that those slots are ignored. Gaps of invalid slots are placed between a taken skip and its victim to exercise the ST_PEND wait.

// File: rtl/bts_pkg.sv
package bts_pkg;
    typedef enum logic [1:0] {
        OPC_NONE  = 2'b00,
        OPC_SKIP1 = 2'b01,
        OPC_SKIP0 = 2'b10,
        OPC_RSVD  = 2'b11
    } opc_e;

    typedef enum logic {
        ST_EVAL = 1'b0,
        ST_PEND = 1'b1
    } skip_st_e;
endpackage

// File: rtl/bts_decode.sv
module bts_decode
    import bts_pkg::*;
(
    input  logic [1:0] op_i,
    output logic       is_test_o,
    output logic       want_one_o
);
    opc_e opc;

    always_comb begin
        opc        = opc_e'(op_i);
        is_test_o  = 1'b0;
        want_one_o = 1'b0;
        unique case (opc)
            OPC_SKIP1: begin
                is_test_o  = 1'b1;
                want_one_o = 1'b1;
            end
            OPC_SKIP0: begin
                is_test_o  = 1'b1;
                want_one_o = 1'b0;
            end
            OPC_NONE, OPC_RSVD: begin
                is_test_o  = 1'b0;
                want_one_o = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/bts_bitsel.sv
module bts_bitsel #(
    parameter int DATA_W = 8,
    localparam int IDX_W = $clog2(DATA_W)
) (
    input  logic [DATA_W-1:0] data_i,
    input  logic [IDX_W-1:0]  idx_i,
    output logic              bit_o
);
    logic [DATA_W-1:0] hit;

    for (genvar g = 0; g < DATA_W; g++) begin : g_lane
        assign hit[g] = data_i[g] & (idx_i == IDX_W'(g));
    end

    assign bit_o = |hit;
endmodule

// File: rtl/bts_ctrl.sv
module bts_ctrl
    import bts_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic slot_valid_i,
    input  logic is_test_i,
    input  logic cond_met_i,
    output logic squash_o,
    output logic pend_o,
    output logic take_o
);
    skip_st_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_EVAL;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d  = state_q;
        squash_o = 1'b0;
        pend_o   = 1'b0;
        take_o   = 1'b0;
        unique case (state_q)
            ST_EVAL: begin
                take_o = slot_valid_i & is_test_i & cond_met_i;
                if (take_o) state_d = ST_PEND;
            end
            ST_PEND: begin
                pend_o   = 1'b1;
                squash_o = slot_valid_i;
                if (slot_valid_i) state_d = ST_EVAL;
            end
        endcase
    end
endmodule

// File: rtl/bts_skip_unit.sv
module bts_skip_unit #(
    parameter int ADDR_W = 7,
    parameter int DATA_W = 8,
    localparam int IDX_W = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              slot_valid_i,
    input  logic [1:0]        op_i,
    input  logic [ADDR_W-1:0] reg_addr_i,
    input  logic [IDX_W-1:0]  bit_sel_i,
    input  logic [DATA_W-1:0] rd_data_i,
    output logic [ADDR_W-1:0] rd_addr_o,
    output logic              squash_o,
    output logic              skip_pend_o,
    output logic              two_cyc_o
);
    logic is_test, want_one, sel_bit, cond_met;

    assign rd_addr_o = reg_addr_i;

    bts_decode u_dec (
        .op_i       (op_i),
        .is_test_o  (is_test),
        .want_one_o (want_one)
    );

    bts_bitsel #(.DATA_W(DATA_W)) u_sel (
        .data_i (rd_data_i),
        .idx_i  (bit_sel_i),
        .bit_o  (sel_bit)
    );

    assign cond_met = ~(sel_bit ^ want_one);

    bts_ctrl u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .slot_valid_i (slot_valid_i),
        .is_test_i    (is_test),
        .cond_met_i   (cond_met),
        .squash_o     (squash_o),
        .pend_o       (skip_pend_o),
        .take_o       (two_cyc_o)
    );
endmodule

// File: rtl/bts_skip_chk.sv
module bts_skip_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       slot_valid_i,
    input logic [1:0] op_i,
    input logic       squash_o,
    input logic       skip_pend_o,
    input logic       two_cyc_o
);
    a_r5_squash_needs_pend: assert property (@(posedge clk) disable iff (!rst_n)
        squash_o |-> skip_pend_o);

    a_r5_pend_clears: assert property (@(posedge clk) disable iff (!rst_n)
        squash_o |=> !skip_pend_o);

    a_r6_pend_waits: assert property (@(posedge clk) disable iff (!rst_n)
        (skip_pend_o && !slot_valid_i) |=> skip_pend_o);

    a_r6_no_idle_squash: assert property (@(posedge clk) disable iff (!rst_n)
        !slot_valid_i |-> !squash_o);

    a_r7_no_eval: assert property (@(posedge clk) disable iff (!rst_n)
        squash_o |-> !two_cyc_o);

    a_r8_pend_source: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(skip_pend_o) |-> $past(two_cyc_o));

    a_r10_other_no_take: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 2'b00 || op_i == 2'b11) |-> !two_cyc_o);
endmodule

bind bts_skip_unit bts_skip_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .slot_valid_i (slot_valid_i),
    .op_i         (op_i),
    .squash_o     (squash_o),
    .skip_pend_o  (skip_pend_o),
    .two_cyc_o    (two_cyc_o)
);

// File: tb/tb_bts_skip_unit.sv
`timescale 1ns/1ps
module tb_bts_skip_unit;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       slot_valid_i = 1'b0;
    logic [1:0] op_i = 2'b00;
    logic [6:0] reg_addr_i = '0;
    logic [2:0] bit_sel_i = '0;
    logic [7:0] rd_data_i;
    logic [6:0] rd_addr_o;
    logic       squash_o, skip_pend_o, two_cyc_o;

    logic [7:0] mem [128];
    int  n_chk = 0, n_err = 0;
    bit  m_pend = 0;
    bit  done = 0;

    always #10 clk = ~clk;

    assign rd_data_i = mem[rd_addr_o];

    bts_skip_unit dut (.*);

    task automatic chk(string tag, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    endtask

    // one slot: drive after falling edge, compare late in low phase, update model at rise
    task automatic step(string tag, bit v, logic [1:0] op, logic [6:0] a, logic [2:0] b);
        bit sq, ev, bv, tk;
        @(negedge clk);
        slot_valid_i = v; op_i = op; reg_addr_i = a; bit_sel_i = b;
        #8;
        sq = m_pend && v;
        ev = v && !m_pend && (op == 2'b01 || op == 2'b10);
        bv = mem[a][b];
        tk = ev && ((op == 2'b01) ? bv : !bv);
        chk("R1", "rd_addr", int'(rd_addr_o), int'(a));
        chk(tag, "squash", int'(squash_o), int'(sq));
        chk(tag, "pend", int'(skip_pend_o), int'(m_pend));
        chk(tag, "two_cyc", int'(two_cyc_o), int'(tk));
        @(posedge clk);
        if (sq) m_pend = 0;
        else if (tk) m_pend = 1;
    endtask

    initial begin
        #3_000_000;
        n_err++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        finish_run();
    end

    initial begin
        for (int i = 0; i < 128; i++) mem[i] = 8'((i * 37 + 5) % 256);
        mem[10] = 8'hA5; mem[11] = 8'h00; mem[12] = 8'hFF;
        #25;
        chk("R9", "pend in reset", int'(skip_pend_o), 0);
        chk("R9", "squash in reset", int'(squash_o), 0);
        @(negedge clk); rst_n = 1'b1;

        // R10: non-test opcodes
        step("R10", 1, 2'b00, 12, 3);
        step("R10", 1, 2'b11, 12, 0);
        // R4 / R2 / R3: every bit index of a mixed byte, both variants
        for (int b = 0; b < 8; b++) begin
            step("R4", 1, 2'b01, 10, 3'(b));
            step("R4", 1, 2'b00, 0, 0);
            step("R4", 1, 2'b10, 10, 3'(b));
            step("R4", 1, 2'b00, 0, 0);
        end
        step("R2", 1, 2'b01, 11, 5);  // bit 0, not taken
        step("R2", 1, 2'b01, 12, 5);  // bit 1, taken
        step("R5", 1, 2'b00, 0, 0);   // squashed
        step("R5", 1, 2'b00, 0, 0);
        step("R3", 1, 2'b10, 12, 2);  // bit 1, not taken
        step("R3", 1, 2'b10, 11, 2);  // taken
        // R6: idle gap with garbage operands
        step("R6", 0, 2'b01, 12, 7);
        step("R6", 0, 2'b10, 11, 1);
        step("R6", 0, 2'b01, 12, 0);
        step("R6", 1, 2'b00, 0, 0);
        // R7: victim is itself a taken test
        step("R7", 1, 2'b01, 12, 4);
        step("R7", 1, 2'b01, 12, 4);
        step("R7", 1, 2'b10, 11, 4);
        step("R7", 1, 2'b00, 0, 0);
        // R9: reset while pending
        step("R9", 1, 2'b01, 12, 1);
        @(negedge clk); rst_n = 1'b0; #2;
        m_pend = 0;
        chk("R9", "pend after reset", int'(skip_pend_o), 0);
        slot_valid_i = 1'b1; op_i = 2'b00; #2;
        chk("R9", "squash after reset", int'(squash_o), 0);
        @(negedge clk); rst_n = 1'b1;
        step("R9", 1, 2'b00, 0, 0);
        // R8: random mix
        for (int k = 0; k < 600; k++) begin
            step("R8", ($urandom % 4) != 0, 2'($urandom), 7'($urandom), 3'($urandom));
        end
        finish_run();
    end
endmodule